// File: doc/BRIEF.md
# Inverse-Time Overcurrent Element with Disk Emulation

This block is the timed overcurrent stage of a protection pipeline. Once per protection interval it receives the largest of the three phase rms current magnitudes. It compares that current with a pickup setting and moves an emulated induction-disk travel. While the current is above pickup, the travel advances toward full scale at a rate set by the moderately inverse operating curve. While the current is at or below pickup, the travel falls back toward zero at a rate set by the reset curve. Both rates shrink in proportion to the time dial.

A serial divider forms the quantized multiple of pickup in steps of 1/8. The multiple addresses two rate tables, one for operating and one for resetting. The tables are computed once, when the design is built, from the curve formulas. A second serial divider scales the selected rate by the time dial, and the step is then added to or taken from the travel. The interval is a quarter cycle of a 60 Hz system, so strobes arrive at 240 Hz. The block gives a pickup flag and a timed-trip flag. The trip flag is sticky: once set, it stays high until the travel has wound all the way back to zero.

Top module: `otc_overcurrent`

## Requirements
- R1: One cycle after a `sample_valid` strobe, `pickup_o` equals (`i_mag` > `pickup_set`). A current exactly equal to pickup does not pick up, and `pickup_o` changes only after a strobe.
- R2: The multiple index is k = floor(8·`i_mag`/`pickup_set`), clamped to 255. The operating rate for index k uses M = (k + 0.5)/8, so a current of 60 times pickup behaves like M = 31.9375.
- R3: While picked up, the trip flag rises after N strobes, counting the strobe that trips. N = 240·tm to within two strobes, where tm = TD·(0.0226 + 0.0104/(M^0.02 − 1)).
- R4: The trip flag rises in the update where the travel reaches full scale. The travel never exceeds full scale, so extra overcurrent strobes after a trip do not lengthen the later reset.
- R5: While not picked up, full travel winds down to zero in 240·1.08·TD/(1 − M²) strobes to within two strobes, with M = k/8. At M = 1 exactly, the travel holds still.
- R6: Once set, `trip_o` stays high until the travel has returned to zero.
- R7: The travel saturates at zero, so strobes below pickup at zero travel do not delay a later trip.
- R8: Synchronous active-high `rst` clears the travel, `pickup_o` and `trip_o`.
- R9: The outputs reflect a strobe no later than 64 cycles after it. Strobes must be at least 64 cycles apart.
- R10: `time_dial` is TD in hundredths (100 is TD = 1.00). Halving it halves both the operating time and the reset time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| sample_valid | input | 1 | one-cycle strobe, one per protection interval |
| i_mag | input | 16 | largest phase rms current magnitude |
| pickup_set | input | 16 | pickup current, same scale as `i_mag` |
| time_dial | input | 16 | time dial in hundredths |
| pickup_o | output | 1 | current is above pickup |
| trip_o | output | 1 | emulated disk has reached full travel |

## Verification
Steady overcurrent at ten times pickup is applied with two dial values. This checks the curve shape and separates it from the dial scaling. A current of sixty times pickup checks the clamp on the multiple index. After a trip, further overcurrent strobes are applied and then a current exactly at pickup; these show saturation at full scale and the frozen travel at M = 1. A current at half of pickup then times the reset curve, and a stretch at zero current followed by a new fault shows the floor at zero. A current one unit above pickup against one exactly at pickup checks the strict comparison, and a reset in the middle of an accumulation shows that the travel is cleared.

// File: rtl/otc_pkg.sv
package otc_pkg;

  // Operating step per interval, scaled by 100 so that a later division by
  // the dial in hundredths yields the step for that dial.
  function automatic longint op_rate(int k, int frac_bits, int full_w, int rate_hz);
    real m;
    real tm;
    m = (real'(k) + 0.5) / real'(1 << frac_bits);
    if (m <= 1.0) return 0;
    tm = 0.0226 + 0.0104 / ((m ** 0.02) - 1.0);
    return longint'($rtoi((2.0 ** full_w) * 100.0 / (real'(rate_hz) * tm)));
  endfunction

  // Reset step per interval from tr = 1.08 * TD / (1 - M^2), same scaling.
  function automatic longint rs_rate(int k, int frac_bits, int full_w, int rate_hz);
    real m;
    m = real'(k) / real'(1 << frac_bits);
    if (m >= 1.0) return 0;
    return longint'($rtoi((2.0 ** full_w) * 100.0 * (1.0 - m * m) /
                          (real'(rate_hz) * 1.08)));
  endfunction

endpackage

// File: rtl/otc_serdiv.sv
module otc_serdiv #(
  parameter int NUM_W = 19,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [CNT_W-1:0] cnt;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic             run;
  logic [DEN_W:0]   trial;

  assign trial = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      quo   <= '0;
      den_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo   <= num;
        den_q <= den;
        rem   <= '0;
        cnt   <= CNT_W'(NUM_W);
        run   <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den_q}) begin
          rem <= DEN_W'(trial - {1'b0, den_q});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/otc_rate_rom.sv
module otc_rate_rom #(
  parameter int IDX_W     = 8,
  parameter int RATE_W    = 32,
  parameter int FRAC_BITS = 3,
  parameter int FULL_W    = 24,
  parameter int RATE_HZ   = 240
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic              sel_op,
  output logic [RATE_W-1:0] rate
);
  localparam int DEPTH = 1 << IDX_W;

  logic [RATE_W-1:0] op_mem [DEPTH];
  logic [RATE_W-1:0] rs_mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      op_mem[k] = RATE_W'(otc_pkg::op_rate(k, FRAC_BITS, FULL_W, RATE_HZ));
      rs_mem[k] = RATE_W'(otc_pkg::rs_rate(k, FRAC_BITS, FULL_W, RATE_HZ));
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rate <= sel_op ? op_mem[addr] : rs_mem[addr];
  end
endmodule

// File: rtl/otc_disk.sv
module otc_disk #(
  parameter int FULL_W = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic            raise,
  input  logic [FULL_W:0] step,
  output logic [FULL_W:0] travel,
  output logic            trip
);
  localparam logic [FULL_W:0] FULL = (FULL_W+1)'(1) << FULL_W;

  logic [FULL_W+1:0] sum;
  logic [FULL_W:0]   nxt;

  always_comb begin
    sum = {1'b0, travel} + {1'b0, step};
    if (raise) nxt = (sum >= {1'b0, FULL}) ? FULL : sum[FULL_W:0];
    else       nxt = (travel > step) ? (travel - step) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      travel <= '0;
      trip   <= 1'b0;
    end else if (upd) begin
      travel <= nxt;
      if (nxt == FULL)    trip <= 1'b1;
      else if (nxt == '0) trip <= 1'b0;
    end
  end
endmodule

// File: rtl/otc_overcurrent.sv
module otc_overcurrent #(
  parameter int MAG_W     = 16,
  parameter int TD_W      = 16,
  parameter int FRAC_BITS = 3,
  parameter int IDX_W     = 8,
  parameter int RATE_W    = 32,
  parameter int FULL_W    = 24,
  parameter int RATE_HZ   = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_valid,
  input  logic [MAG_W-1:0] i_mag,
  input  logic [MAG_W-1:0] pickup_set,
  input  logic [TD_W-1:0]  time_dial,
  output logic             pickup_o,
  output logic             trip_o
);
  localparam int NUM_W = MAG_W + FRAC_BITS;
  localparam logic [RATE_W-1:0] STEP_MAX = RATE_W'(1) << FULL_W;

  logic [TD_W-1:0]   td_q;
  logic              ratio_done;
  logic [NUM_W-1:0]  ratio_q;
  logic [IDX_W-1:0]  idx;
  logic [RATE_W-1:0] rate;
  logic              rate_vld;
  logic              step_upd;
  logic [RATE_W-1:0] step_q;
  logic [FULL_W:0]   step;
  logic [FULL_W:0]   travel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pickup_o <= 1'b0;
      td_q     <= '0;
      rate_vld <= 1'b0;
    end else begin
      rate_vld <= ratio_done;
      if (sample_valid) begin
        pickup_o <= i_mag > pickup_set;
        td_q     <= time_dial;
      end
    end
  end

  otc_serdiv #(.NUM_W(NUM_W), .DEN_W(MAG_W)) u_ratio (
    .clk(clk), .rst(rst), .start(sample_valid),
    .num({i_mag, FRAC_BITS'(0)}), .den(pickup_set),
    .done(ratio_done), .quo(ratio_q)
  );

  assign idx = (|ratio_q[NUM_W-1:IDX_W]) ? '1 : ratio_q[IDX_W-1:0];

  otc_rate_rom #(.IDX_W(IDX_W), .RATE_W(RATE_W), .FRAC_BITS(FRAC_BITS),
                 .FULL_W(FULL_W), .RATE_HZ(RATE_HZ)) u_rom (
    .clk(clk), .rd_en(ratio_done), .addr(idx), .sel_op(pickup_o), .rate(rate)
  );

  otc_serdiv #(.NUM_W(RATE_W), .DEN_W(TD_W)) u_dial (
    .clk(clk), .rst(rst), .start(rate_vld),
    .num(rate), .den(td_q),
    .done(step_upd), .quo(step_q)
  );

  assign step = (step_q > STEP_MAX) ? STEP_MAX[FULL_W:0] : step_q[FULL_W:0];

  otc_disk #(.FULL_W(FULL_W)) u_disk (
    .clk(clk), .rst(rst), .upd(step_upd), .raise(pickup_o),
    .step(step), .travel(travel), .trip(trip_o)
  );
endmodule

// File: rtl/otc_overcurrent_chk.sv
module otc_overcurrent_chk #(
  parameter int FULL_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            sample_valid,
  input logic            pickup_o,
  input logic            trip_o,
  input logic            upd,
  input logic [FULL_W:0] travel
);
  localparam logic [FULL_W:0] FULL = (FULL_W+1)'(1) << FULL_W;

  assert_trip_at_full_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> travel == FULL);

  assert_travel_cap_R4: assert property (@(posedge clk) disable iff (rst)
    travel <= FULL);

  assert_trip_hold_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(trip_o) |-> travel == '0);

  assert_pickup_on_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> $stable(pickup_o));

  assert_travel_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(travel));

  assert_trip_needs_pickup_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_o) |-> pickup_o);
endmodule

bind otc_overcurrent otc_overcurrent_chk #(.FULL_W(FULL_W)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .pickup_o(pickup_o),
  .trip_o(trip_o), .upd(step_upd), .travel(u_disk.travel)
);

// File: tb/otc_overcurrent_test.sv
module otc_overcurrent_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 64;
  localparam int GAP        = 80;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_valid = 1'b0;
  logic [15:0] i_mag = '0;
  logic [15:0] pickup_set = 16'd1000;
  logic [15:0] time_dial = 16'd100;
  logic        pickup_o;
  logic        trip_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  logic pk_early;

  always #(CLK_PERIOD/2) clk = ~clk;

  otc_overcurrent uut (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .i_mag(i_mag),
    .pickup_set(pickup_set), .time_dial(time_dial),
    .pickup_o(pickup_o), .trip_o(trip_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One interval: strobe, sample pickup one cycle later, settle window (R9).
  task automatic step(input int mag);
    @(negedge clk);
    i_mag = 16'(mag);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    pk_early = pickup_o;
    repeat (SETTLE - 1) @(negedge clk);
  endtask

  task automatic idle_gap();
    repeat (GAP - SETTLE) @(negedge clk);
  endtask

  function automatic real op_steps(real m, int td);
    real tm;
    tm = 0.0226 + 0.0104 / ((m ** 0.02) - 1.0);
    return 240.0 * tm * real'(td) / 100.0;
  endfunction

  function automatic real rs_steps(real m, int td);
    return 240.0 * 1.08 * (real'(td) / 100.0) / (1.0 - m * m);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_to_trip(input int mag, input int td, input real m_eff,
                             input string tag);
    int n = 0;
    int exp;
    time_dial = 16'(td);
    exp = $rtoi(op_steps(m_eff, td) + 0.999);
    while (!trip_o && n < 400) begin
      step(mag);
      idle_gap();
      n++;
    end
    chk((n >= exp - 2) && (n <= exp + 2), tag, n, exp);
  endtask

  task automatic t_reset_state();
    chk(pickup_o == 1'b0, "R8 pickup after reset", int'(pickup_o), 0);
    chk(trip_o == 1'b0, "R8 trip after reset", int'(trip_o), 0);
  endtask

  task automatic t_pickup_edge();
    time_dial = 16'd100;
    step(1000); idle_gap();
    chk(pk_early == 1'b0, "R1 equal current no pickup", int'(pk_early), 0);
    step(1001);
    chk(pk_early == 1'b1, "R1 pickup one cycle after strobe", int'(pk_early), 1);
    chk(trip_o == 1'b0, "R3 no trip after one strobe", int'(trip_o), 0);
    idle_gap();
    repeat (5) begin step(0); idle_gap(); end
    chk(pickup_o == 1'b0, "R1 pickup drops", int'(pickup_o), 0);
  endtask

  task automatic t_operate_m10();
    run_to_trip(10000, 100, 10.0625, "R3 trip time M=10 TD=1.00");
    chk(pickup_o == 1'b1, "R3 pickup at trip", int'(pickup_o), 1);
    do_reset();
  endtask

  task automatic t_dial_half();
    run_to_trip(10000, 50, 10.0625, "R10 trip time M=10 TD=0.50");
    do_reset();
  endtask

  task automatic t_clamp_and_reset();
    int n = 0;
    int exp;
    run_to_trip(60000, 50, 31.9375, "R2 clamped index trip time");
    repeat (10) begin step(60000); idle_gap(); end
    chk(trip_o == 1'b1, "R4 trip high after extra strobes", int'(trip_o), 1);
    repeat (20) begin step(1000); idle_gap(); end
    chk(pickup_o == 1'b0, "R5 at pickup not picked up", int'(pickup_o), 0);
    chk(trip_o == 1'b1, "R5 travel frozen at M=1", int'(trip_o), 1);
    step(500); idle_gap(); n = 1;
    chk(trip_o == 1'b1, "R6 trip held during decay", int'(trip_o), 1);
    exp = $rtoi(rs_steps(0.5, 50) + 0.999);
    while (trip_o && n < 400) begin
      step(500); idle_gap();
      n++;
    end
    chk((n >= exp - 2) && (n <= exp + 2), "R5 reset time from full M=0.5", n, exp);
  endtask

  task automatic t_floor_zero();
    repeat (10) begin step(0); idle_gap(); end
    chk(trip_o == 1'b0, "R7 trip low at zero travel", int'(trip_o), 0);
    run_to_trip(10000, 50, 10.0625, "R7 fresh trip after floor");
  endtask

  task automatic t_mid_reset();
    do_reset();
    time_dial = 16'd100;
    repeat (30) begin step(10000); idle_gap(); end
    do_reset();
    chk(trip_o == 1'b0, "R8 trip cleared", int'(trip_o), 0);
    chk(pickup_o == 1'b0, "R8 pickup cleared", int'(pickup_o), 0);
    run_to_trip(10000, 100, 10.0625, "R8 full time after reset");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_pickup_edge();
    t_operate_m10();
    t_dial_half();
    t_clamp_and_reset();
    t_floor_zero();
    t_mid_reset();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule